// File: doc/BRIEF.md
# Interleaved Bank Read Pattern Generator

This block produces an endless, repeating DDR SDRAM command stream meant for current-measurement and stress traffic. Each clock slot carries exactly one command (activate, read, precharge or no-operation) together with a bank number and a pseudo-random row and column. The command sequence comes from a fixed slot table picked by two configuration inputs. One input chooses between a single-bank mode and a four-bank interleaved mode. The other chooses between the slowest speed grade and the faster ones. In single-bank mode one bank is opened, read and closed explicitly. In four-bank mode the activate for the next bank is placed between the reads of earlier banks, and every read closes its own row through auto-precharge.

A run input starts the stream and stops it, but both take effect only at the end of a full sequence. This keeps every emitted sequence complete. The configuration is also sampled only at that boundary. While stopped, the block outputs no-operation with the valid strobe low. A 16-bit maximal-length LFSR holds the address. It is loaded with a fixed nonzero seed at reset and advances once per completed sequence, so the address is new on each repetition and constant within one.

Top module: `ilv_pattern_gen`

## Requirements
- R1: While reset is asserted and after it is released with run low, valid_o is 0, cmd_o is no-operation (code 0), and row_o/col_o show the seed 16'hACE1 split as row = LFSR[12:0] and col = LFSR[15:6] (row 13'h0CE1, col 10'h2B3).
- R2: Single-bank mode with the slow grade (four_bank_i=0, fast_i=0) repeats the 7 slots ACT, NOP, RD, NOP, NOP, PRE, NOP.
- R3: Single-bank mode with the fast grade (four_bank_i=0, fast_i=1) repeats the 9 slots ACT, NOP, NOP, RD, NOP, PRE, NOP, NOP, NOP.
- R4: Four-bank mode with the slow grade (four_bank_i=1, fast_i=0) repeats the 12 slots ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, ACT b0, RD b3, ACT b1, RD b0.
- R5: Four-bank mode with the fast grade (four_bank_i=1, fast_i=1) repeats the 14 slots ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, NOP, RD b3, ACT b0, NOP, ACT b1, RD b0.
- R6: Command codes on cmd_o are NOP=0, ACT=1, RD=2, WR=3, PRE=4. WR is never emitted. Single-bank mode uses bank 0 with auto_pre_o low. In four-bank mode every RD has auto_pre_o high and PRE never appears.
- R7: row_o and col_o stay fixed across a sequence. At each sequence end the LFSR steps as next = {q[14:0], q[15]^q[13]^q[12]^q[10]}, and the LFSR never holds zero.
- R8: When run_i is high at a boundary (idle, or on the last slot of a sequence), slot 0 of the sequence selected by four_bank_i/fast_i appears on the next cycle, with no gap. Changes to the configuration inputs in the middle of a sequence have no effect.
- R9: When run_i is low at a boundary, the stream stops after the last slot and outputs NOP with valid_o low. Dropping run_i in the middle of a sequence does not cut that sequence short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start/continue request, sampled at sequence boundaries |
| four_bank_i | input | 1 | 1 = four-bank interleaved mode, 0 = single-bank mode |
| fast_i | input | 1 | 1 = faster speed-grade table, 0 = slowest grade table |
| cmd_o | output | 3 | Command code for this slot |
| bank_o | output | 2 | Bank select |
| auto_pre_o | output | 1 | Auto-precharge flag accompanying a read |
| row_o | output | ROW_W | Pseudo-random row address |
| col_o | output | COL_W | Pseudo-random column address |
| valid_o | output | 1 | High while a sequence slot is being emitted |

## Verification
Two events can land in the same cycle: the final slot of a sequence, and a change of the run or configuration inputs. The same edge decides whether the stream stops, restarts or switches tables, and it is also the edge on which the address LFSR steps. The bench provokes this by dropping run, or by switching from single-bank to four-bank mode, exactly on the last slot. It then expects either an immediate idle NOP or slot 0 of the new table with the stepped address and no gap. It also drops run and flips the configuration in the middle of a sequence, and expects the sequence to finish unchanged before the stream stops.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int BANK_W = 2;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic              ap;
        logic              last;
    } slot_t;

    typedef struct packed {
        logic             run;
        logic             four_bank;
        logic             fast;
        logic [IDX_W-1:0] idx;
        slot_t            slot;
    } ctl_t;

    function automatic slot_t mk_slot(cmd_e c, logic [BANK_W-1:0] b, logic ap, logic last);
        slot_t s;
        s.cmd  = c;
        s.bank = b;
        s.ap   = ap;
        s.last = last;
        return s;
    endfunction

endpackage

// File: rtl/ilv_lfsr.sv
module ilv_lfsr #(
    parameter int           W     = 16,
    parameter logic [W-1:0] TAPS  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d = {st_q[W-2:0], ^(st_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/ilv_slot_rom.sv
module ilv_slot_rom
    import ilv_pkg::*;
(
    input  logic             four_bank_i,
    input  logic             fast_i,
    input  logic [IDX_W-1:0] idx_i,
    output slot_t            slot_o
);

    slot_t s_single_slow, s_single_fast, s_quad_slow, s_quad_fast;

    always_comb begin
        case (idx_i)
            4'd0:    s_single_slow = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd2:    s_single_slow = mk_slot(CMD_RD,  2'd0, 1'b0, 1'b0);
            4'd5:    s_single_slow = mk_slot(CMD_PRE, 2'd0, 1'b0, 1'b0);
            4'd1, 4'd3, 4'd4:
                     s_single_slow = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            default: s_single_slow = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b1);
        endcase
    end

    always_comb begin
        case (idx_i)
            4'd0:    s_single_fast = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd3:    s_single_fast = mk_slot(CMD_RD,  2'd0, 1'b0, 1'b0);
            4'd5:    s_single_fast = mk_slot(CMD_PRE, 2'd0, 1'b0, 1'b0);
            4'd1, 4'd2, 4'd4, 4'd6, 4'd7:
                     s_single_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            default: s_single_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b1);
        endcase
    end

    always_comb begin
        case (idx_i)
            4'd0:    s_quad_slow = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd1:    s_quad_slow = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            4'd2:    s_quad_slow = mk_slot(CMD_ACT, 2'd1, 1'b0, 1'b0);
            4'd3:    s_quad_slow = mk_slot(CMD_RD,  2'd0, 1'b1, 1'b0);
            4'd4:    s_quad_slow = mk_slot(CMD_ACT, 2'd2, 1'b0, 1'b0);
            4'd5:    s_quad_slow = mk_slot(CMD_RD,  2'd1, 1'b1, 1'b0);
            4'd6:    s_quad_slow = mk_slot(CMD_ACT, 2'd3, 1'b0, 1'b0);
            4'd7:    s_quad_slow = mk_slot(CMD_RD,  2'd2, 1'b1, 1'b0);
            4'd8:    s_quad_slow = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd9:    s_quad_slow = mk_slot(CMD_RD,  2'd3, 1'b1, 1'b0);
            4'd10:   s_quad_slow = mk_slot(CMD_ACT, 2'd1, 1'b0, 1'b0);
            4'd11:   s_quad_slow = mk_slot(CMD_RD,  2'd0, 1'b1, 1'b1);
            default: s_quad_slow = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b1);
        endcase
    end

    always_comb begin
        case (idx_i)
            4'd0:    s_quad_fast = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd1:    s_quad_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            4'd2:    s_quad_fast = mk_slot(CMD_ACT, 2'd1, 1'b0, 1'b0);
            4'd3:    s_quad_fast = mk_slot(CMD_RD,  2'd0, 1'b1, 1'b0);
            4'd4:    s_quad_fast = mk_slot(CMD_ACT, 2'd2, 1'b0, 1'b0);
            4'd5:    s_quad_fast = mk_slot(CMD_RD,  2'd1, 1'b1, 1'b0);
            4'd6:    s_quad_fast = mk_slot(CMD_ACT, 2'd3, 1'b0, 1'b0);
            4'd7:    s_quad_fast = mk_slot(CMD_RD,  2'd2, 1'b1, 1'b0);
            4'd8:    s_quad_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            4'd9:    s_quad_fast = mk_slot(CMD_RD,  2'd3, 1'b1, 1'b0);
            4'd10:   s_quad_fast = mk_slot(CMD_ACT, 2'd0, 1'b0, 1'b0);
            4'd11:   s_quad_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b0);
            4'd12:   s_quad_fast = mk_slot(CMD_ACT, 2'd1, 1'b0, 1'b0);
            4'd13:   s_quad_fast = mk_slot(CMD_RD,  2'd0, 1'b1, 1'b1);
            default: s_quad_fast = mk_slot(CMD_NOP, 2'd0, 1'b0, 1'b1);
        endcase
    end

    always_comb begin
        case ({four_bank_i, fast_i})
            2'b00:   slot_o = s_single_slow;
            2'b01:   slot_o = s_single_fast;
            2'b10:   slot_o = s_quad_slow;
            default: slot_o = s_quad_fast;
        endcase
    end

endmodule

// File: rtl/ilv_pattern_gen.sv
module ilv_pattern_gen
    import ilv_pkg::*;
#(
    parameter int               ROW_W  = 13,
    parameter int               COL_W  = 10,
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              four_bank_i,
    input  logic              fast_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              auto_pre_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o
);

    localparam logic [LFSR_W-1:0] TAPS = 16'hB400;

    ctl_t              ctl_d, ctl_q;
    slot_t             rom_slot;
    logic              rom_four, rom_fast;
    logic [IDX_W-1:0]  rom_idx;
    logic              boundary;
    logic              lfsr_step;
    logic [LFSR_W-1:0] lfsr_q;
    logic              four_bank_q;
    logic              last_q;

    ilv_slot_rom u_rom (
        .four_bank_i (rom_four),
        .fast_i      (rom_fast),
        .idx_i       (rom_idx),
        .slot_o      (rom_slot)
    );

    ilv_lfsr #(
        .W    (LFSR_W),
        .TAPS (TAPS),
        .SEED (SEED)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (lfsr_step),
        .state_o (lfsr_q)
    );

    always_comb begin
        ctl_d     = ctl_q;
        boundary  = !ctl_q.run || ctl_q.slot.last;
        lfsr_step = ctl_q.run && ctl_q.slot.last;

        rom_four  = boundary ? four_bank_i : ctl_q.four_bank;
        rom_fast  = boundary ? fast_i      : ctl_q.fast;
        rom_idx   = boundary ? '0 : IDX_W'(ctl_q.idx + 1'b1);

        if (boundary) begin
            ctl_d.run       = run_i;
            ctl_d.four_bank = run_i ? four_bank_i : ctl_q.four_bank;
            ctl_d.fast      = run_i ? fast_i      : ctl_q.fast;
            ctl_d.idx       = '0;
        end else begin
            ctl_d.idx       = rom_idx;
        end

        if (ctl_d.run) begin
            ctl_d.slot = rom_slot;
        end else begin
            ctl_d.slot = mk_slot(CMD_NOP, '0, 1'b0, 1'b0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign four_bank_q = ctl_q.four_bank;
    assign last_q      = ctl_q.slot.last;

    assign cmd_o      = ctl_q.slot.cmd;
    assign bank_o     = ctl_q.slot.bank;
    assign auto_pre_o = ctl_q.slot.ap;
    assign valid_o    = ctl_q.run;
    assign row_o      = lfsr_q[ROW_W-1:0];
    assign col_o      = lfsr_q[LFSR_W-1 -: COL_W];

endmodule

// File: rtl/ilv_pattern_gen_chk.sv
module ilv_pattern_gen_chk
    import ilv_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int LFSR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_o,
    input logic [2:0]        cmd_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              auto_pre_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [COL_W-1:0]  col_o,
    input logic              four_bank_q,
    input logic              last_q,
    input logic [LFSR_W-1:0] lfsr_q
);

    a_r9_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (cmd_o == CMD_NOP) && !auto_pre_o);

    a_r9_no_midstop: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_q |=> valid_o);

    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_q |=> $stable(row_o) && $stable(col_o));

    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    a_r7_step_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_q |=> lfsr_q != $past(lfsr_q));

    a_r6_single_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !four_bank_q |-> (bank_o == '0) && !auto_pre_o);

    a_r6_quad_no_pre: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && four_bank_q |-> cmd_o != CMD_PRE);

    a_r6_quad_rd_ap: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && four_bank_q && (cmd_o == CMD_RD) |-> auto_pre_o);

    a_r6_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o != CMD_WR);

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_q |=> $stable(four_bank_q));

endmodule

bind ilv_pattern_gen ilv_pattern_gen_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .LFSR_W (LFSR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_o     (valid_o),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .auto_pre_o  (auto_pre_o),
    .row_o       (row_o),
    .col_o       (col_o),
    .four_bank_q (four_bank_q),
    .last_q      (last_q),
    .lfsr_q      (lfsr_q)
);

// File: tb/ilv_pattern_gen_bench.sv
module ilv_pattern_gen_bench;

    localparam int ROW_W = 13;
    localparam int COL_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_i = 1'b0;
    logic              four_bank_i = 1'b0;
    logic              fast_i = 1'b0;
    logic [2:0]        cmd_o;
    logic [1:0]        bank_o;
    logic              auto_pre_o;
    logic [ROW_W-1:0]  row_o;
    logic [COL_W-1:0]  col_o;
    logic              valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    ilv_pattern_gen u_ilv_pattern_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_i),
        .four_bank_i (four_bank_i),
        .fast_i      (fast_i),
        .cmd_o       (cmd_o),
        .bank_o      (bank_o),
        .auto_pre_o  (auto_pre_o),
        .row_o       (row_o),
        .col_o       (col_o),
        .valid_o     (valid_o)
    );

    function automatic logic [15:0] lfsr_next(logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    function automatic int seq_len(bit m, bit g);
        if (m) return g ? 14 : 12;
        return g ? 9 : 7;
    endfunction

    // {cmd[2:0], bank[1:0], ap}; NOP=0 ACT=1 RD=2 PRE=4
    function automatic logic [5:0] ref_slot(bit m, bit g, int i);
        int k;
        if (!m) begin
            if (i == 0) return {3'd1, 2'd0, 1'b0};
            if (i == (g ? 3 : 2)) return {3'd2, 2'd0, 1'b0};
            if (i == 5) return {3'd4, 2'd0, 1'b0};
            return 6'd0;
        end
        if (i == 1) return 6'd0;
        k = i;
        if (g) begin
            if (i == 8 || i == 11) return 6'd0;
            if (i == 10) k = 8;
            if (i == 12) k = 10;
            if (i == 13) k = 11;
        end
        if (k % 2 == 0) return {3'd1, 2'((k / 2) % 4), 1'b0};
        return {3'd2, 2'(((k - 3) / 2) % 4), 1'b1};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        chk(valid_o == 1'b0, req, 32'(valid_o), 0);
        chk(cmd_o == 3'd0 && auto_pre_o == 1'b0, req, 32'({cmd_o, auto_pre_o}), 0);
        chk(row_o == exp_lfsr[12:0], req, 32'(row_o), 32'(exp_lfsr[12:0]));
        chk(col_o == exp_lfsr[15:6], req, 32'(col_o), 32'(exp_lfsr[15:6]));
    endtask

    task automatic check_slot(bit m, bit g, int i);
        logic [5:0] e;
        string req;
        e = ref_slot(m, g, i);
        req = m ? (g ? "R5" : "R4") : (g ? "R3" : "R2");
        chk(valid_o == 1'b1, req, 32'(valid_o), 1);
        chk({cmd_o, bank_o, auto_pre_o} == e, req, 32'({cmd_o, bank_o, auto_pre_o}), 32'(e));
        chk(row_o == exp_lfsr[12:0] && col_o == exp_lfsr[15:6], "R7",
            32'({col_o, row_o}), 32'({exp_lfsr[15:6], exp_lfsr[12:0]}));
    endtask

    // Play reps sequences; optionally drop run and flip config mid first rep.
    task automatic play(bit m, bit g, int reps, int flip_at, bit next_run, bit nm, bit ng);
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i < seq_len(m, g); i++) begin
                @(negedge clk);
                check_slot(m, g, i);
                if (r == 0 && i == flip_at) begin
                    run_i       = 1'b0;
                    four_bank_i = !m;
                    fast_i      = !g;
                end
                if (i == seq_len(m, g) - 1) begin
                    exp_lfsr = lfsr_next(exp_lfsr);
                    if (r == reps - 1) begin
                        run_i = next_run; four_bank_i = nm; fast_i = ng;
                    end else begin
                        run_i = 1'b1; four_bank_i = m; fast_i = g;
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R9 watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check_idle("R1");
        end
        chk(row_o == 13'h0CE1, "R1", 32'(row_o), 32'h0CE1);
        chk(col_o == 10'h2B3, "R1", 32'(col_o), 32'h2B3);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_idle("R1");
        end

        // R2..R5 over several repetitions, stop at the end (R9)
        for (int c = 0; c < 4; c++) begin
            run_i = 1'b1; four_bank_i = c[1]; fast_i = c[0];
            play(c[1], c[0], 3, -1, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            check_idle("R9");
            @(negedge clk);
            check_idle("R9");
        end

        // R9/R8: run dropped and config flipped mid-sequence, ignored
        run_i = 1'b1; four_bank_i = 1'b1; fast_i = 1'b1;
        play(1'b1, 1'b1, 1, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_idle("R9");

        // R8: mode switch exactly at the boundary, no gap
        run_i = 1'b1; four_bank_i = 1'b0; fast_i = 1'b0;
        play(1'b0, 1'b0, 1, -1, 1'b1, 1'b1, 1'b0);
        play(1'b1, 1'b0, 2, -1, 1'b1, 1'b0, 1'b1);
        play(1'b0, 1'b1, 1, -1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_idle("R8");
        chk(exp_lfsr != 16'h0, "R7", 32'(exp_lfsr), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule